// File: doc/BRIEF.md
# Halt Mode Clock Wake Sequencer

The sequencer controls entry into and exit from a deep halt power mode. When the processor issues an idle request while halt mode is selected, the block keeps the core clock running for a fixed drain interval so that pending pipeline work can finish. It then gates the core clock and drops both the oscillator enable and the PLL enable. From there the device sleeps until a wake pin or the reset pin produces a qualified low pulse.

Wake-up runs in two phases. The falling edge of the pin only restarts the oscillator. The rising edge enables the PLL and starts a long lock count, and the core clock stays gated during that count. A resume latency then follows. Its length depends on whether execution restarts from on-chip RAM or from a flash array that was asleep. The status output `resume_o` shows when execution may continue. The `state_o` port exposes the controller state for observation.

All counts are taken in the single clock `clk_i`. The input clock and the system clock are treated as the same clock. Pins are assumed to be synchronous to `clk_i`.

Top module: `halt_wake_seq`

## Requirements
- R1: While reset is low, and after it is released, the state is running (0) and `osc_en_o`, `pll_en_o`, `core_clk_en_o` and `resume_o` are all 1.
- R2: An idle request with `halt_sel_i` = 1 moves the block from running to flushing (1). An idle request with `halt_sel_i` = 0 is ignored, and the block stays in running with `resume_o` = 1.
- R3: Flushing lasts exactly FLUSH_CYC (32) cycles with `core_clk_en_o` = 1 and `resume_o` = 0, and then the block enters halted (2).
- R4: In halted, `osc_en_o`, `pll_en_o` and `core_clk_en_o` are all 0.
- R5: A falling edge on `wake_ni` in halted moves the block to oscillator-up (3), with `osc_en_o` = 1, `pll_en_o` = 0 and `core_clk_en_o` = 0, for as long as the pin stays low.
- R6: When `wake_ni` rises, a low pulse of at least WAKE_MIN (2) cycles moves the block to PLL-locking (4). A shorter pulse returns the block to halted.
- R7: PLL-locking lasts exactly LOCK_CYC cycles with `pll_en_o` = 1 and `core_clk_en_o` = 0, and then the block enters resuming (5).
- R8: Resuming lasts RES_RAM (35) cycles if `flash_sleep_i` was 0 when flushing began, or RES_FLASH (1125) cycles if it was 1. Changes on `flash_sleep_i` after that point have no effect. During resuming `core_clk_en_o` = 1 and `resume_o` = 0. Afterwards the block returns to running.
- R9: A low pulse on `rpin_ni` also wakes the block from halted. It reaches PLL-locking only if the pulse lasts at least RPIN_MIN (8) cycles. Otherwise the block returns to halted.
- R10: `state_o` never takes a value other than the six encodings 0 to 5.
- R11: Wake is edge sensitive. A pin that is already low when halted is entered does not wake the block until it rises and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used for every count |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_req_i | input | 1 | Idle request from the processor |
| halt_sel_i | input | 1 | 1 selects halt as the low-power mode |
| flash_sleep_i | input | 1 | 1 means resume from sleeping flash, 0 means from RAM |
| wake_ni | input | 1 | Active-low wake pin |
| rpin_ni | input | 1 | Active-low reset pin, also usable as a wake source |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| core_clk_en_o | output | 1 | Core clock gate enable |
| resume_o | output | 1 | 1 when execution may proceed |
| state_o | output | 3 | Controller state encoding |

## Verification
The full halt/wake cycle is run with a table of scenarios. The scenarios differ in the mode select, the latched memory choice, the wake source and the pulse length. Two pulse lengths sit just below and just at the minimum for each source, which separates the two limits and their off-by-one edges. Both memory choices are exercised, and `flash_sleep_i` is flipped after entry, so that a latched choice can be told apart from a live one. Directed tests cover the reset state and a pin already held low at halt entry, to show that the wake is edge sensitive and not level sensitive.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_FLUSH  = 3'd1,
    ST_HALT   = 3'd2,
    ST_OSC    = 3'd3,
    ST_LOCK   = 3'd4,
    ST_RESUME = 3'd5
  } hws_state_e;
endpackage

// File: rtl/hws_down_cnt.sv
module hws_down_cnt #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // counter never wraps through zero
  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/hws_pin_qual.sv
module hws_pin_qual #(
  parameter int MIN = 2,
  localparam int W = $clog2(MIN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fell_o,
  output logic rose_o,
  output logic long_o
);
  logic         prev_q;
  logic [W-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      low_q  <= '0;
    end else begin
      prev_q <= pin_ni;
      if (pin_ni)                 low_q <= '0;
      else if (low_q != W'(MIN))  low_q <= low_q + 1'b1;
    end
  end

  assign fell_o = prev_q && !pin_ni;
  assign rose_o = !prev_q && pin_ni;
  assign long_o = (low_q >= W'(MIN));

  assert_rise_after_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rose_o |-> (low_q != '0));
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm
  import hws_pkg::*;
#(
  parameter int FLUSH_CYC = 32,
  parameter int LOCK_CYC  = 131072,
  parameter int RES_RAM   = 35,
  parameter int RES_FLASH = 1125,
  parameter int CW        = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_req_i,
  input  logic          halt_sel_i,
  input  logic          flash_sleep_i,
  input  logic          wake_fell_i,
  input  logic          wake_rose_i,
  input  logic          wake_long_i,
  input  logic          rpin_fell_i,
  input  logic          rpin_rose_i,
  input  logic          rpin_long_i,
  input  logic          cnt_zero_i,
  output hws_state_e    state_o,
  output logic          cnt_load_o,
  output logic [CW-1:0] cnt_val_o,
  output logic          cnt_dec_o
);
  hws_state_e state_q, state_d;
  logic flash_q, flash_d;
  logic src_q, src_d;  // 1: reset pin woke us
  logic rel, long_ok;

  assign rel     = src_q ? rpin_rose_i : wake_rose_i;
  assign long_ok = src_q ? rpin_long_i : wake_long_i;

  always_comb begin
    state_d    = state_q;
    flash_d    = flash_q;
    src_d      = src_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    unique case (state_q)
      ST_RUN: if (idle_req_i && halt_sel_i) begin
        state_d    = ST_FLUSH;
        flash_d    = flash_sleep_i;
        cnt_load_o = 1'b1;
        cnt_val_o  = CW'(FLUSH_CYC - 1);
      end
      ST_FLUSH: if (cnt_zero_i) state_d = ST_HALT;
      ST_HALT: begin
        if (wake_fell_i) begin
          state_d = ST_OSC;
          src_d   = 1'b0;
        end else if (rpin_fell_i) begin
          state_d = ST_OSC;
          src_d   = 1'b1;
        end
      end
      ST_OSC: if (rel) begin
        if (long_ok) begin
          state_d    = ST_LOCK;
          cnt_load_o = 1'b1;
          cnt_val_o  = CW'(LOCK_CYC - 1);
        end else begin
          state_d = ST_HALT;
        end
      end
      ST_LOCK: if (cnt_zero_i) begin
        state_d    = ST_RESUME;
        cnt_load_o = 1'b1;
        cnt_val_o  = flash_q ? CW'(RES_FLASH - 1) : CW'(RES_RAM - 1);
      end
      ST_RESUME: if (cnt_zero_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  assign cnt_dec_o = (state_q inside {ST_FLUSH, ST_LOCK, ST_RESUME}) && !cnt_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      flash_q <= 1'b0;
      src_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      flash_q <= flash_d;
      src_q   <= src_d;
    end
  end

  assign state_o = state_q;

  assert_osc_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OSC) |=> (state_q inside {ST_OSC, ST_LOCK, ST_HALT}));
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import hws_pkg::*;
#(
  parameter int FLUSH_CYC = 32,
  parameter int LOCK_CYC  = 131072,
  parameter int RES_RAM   = 35,
  parameter int RES_FLASH = 1125,
  parameter int WAKE_MIN  = 2,
  parameter int RPIN_MIN  = 8,
  localparam int MAXC     = (LOCK_CYC > RES_FLASH) ? LOCK_CYC : RES_FLASH,
  localparam int CW       = $clog2(MAXC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_req_i,
  input  logic       halt_sel_i,
  input  logic       flash_sleep_i,
  input  logic       wake_ni,
  input  logic       rpin_ni,
  output logic       osc_en_o,
  output logic       pll_en_o,
  output logic       core_clk_en_o,
  output logic       resume_o,
  output logic [2:0] state_o
);
  hws_state_e st;
  logic w_fell, w_rose, w_long, r_fell, r_rose, r_long;
  logic c_load, c_dec, c_zero;
  logic [CW-1:0] c_val;

  hws_pin_qual #(.MIN(WAKE_MIN)) u_wake (
    .clk_i, .rst_ni, .pin_ni(wake_ni),
    .fell_o(w_fell), .rose_o(w_rose), .long_o(w_long));

  hws_pin_qual #(.MIN(RPIN_MIN)) u_rpin (
    .clk_i, .rst_ni, .pin_ni(rpin_ni),
    .fell_o(r_fell), .rose_o(r_rose), .long_o(r_long));

  hws_down_cnt #(.W(CW)) u_cnt (
    .clk_i, .rst_ni, .load_i(c_load), .load_val_i(c_val),
    .dec_i(c_dec), .zero_o(c_zero));

  hws_fsm #(
    .FLUSH_CYC(FLUSH_CYC), .LOCK_CYC(LOCK_CYC),
    .RES_RAM(RES_RAM), .RES_FLASH(RES_FLASH), .CW(CW)
  ) u_fsm (
    .clk_i, .rst_ni, .idle_req_i, .halt_sel_i, .flash_sleep_i,
    .wake_fell_i(w_fell), .wake_rose_i(w_rose), .wake_long_i(w_long),
    .rpin_fell_i(r_fell), .rpin_rose_i(r_rose), .rpin_long_i(r_long),
    .cnt_zero_i(c_zero), .state_o(st),
    .cnt_load_o(c_load), .cnt_val_o(c_val), .cnt_dec_o(c_dec));

  assign osc_en_o      = (st != ST_HALT);
  assign pll_en_o      = !(st inside {ST_HALT, ST_OSC});
  assign core_clk_en_o = !(st inside {ST_HALT, ST_OSC, ST_LOCK});
  assign resume_o      = (st == ST_RUN);
  assign state_o       = st;

  assert_ignore_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && idle_req_i && !halt_sel_i) |=> (st == ST_RUN));
  assert_flush_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_FLUSH) |=> (st inside {ST_FLUSH, ST_HALT}));
  assert_halt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_HALT && wake_ni && rpin_ni) |=> (st == ST_HALT));
  assert_lock_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_LOCK) |=> (st inside {ST_LOCK, ST_RESUME}));
  assert_resume_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RESUME) |=> (st inside {ST_RESUME, ST_RUN}));
  assert_legal_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5);
endmodule

// File: tb/sim_halt_wake_seq.sv
module sim_halt_wake_seq;
  localparam int LOCK = 64;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic idle_req_i = 1'b0, halt_sel_i = 1'b0, flash_sleep_i = 1'b0;
  logic wake_ni = 1'b1, rpin_ni = 1'b1;
  logic osc_en_o, pll_en_o, core_clk_en_o, resume_o;
  logic [2:0] state_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  halt_wake_seq #(.LOCK_CYC(LOCK)) u0 (
    .clk_i(clk), .rst_ni, .idle_req_i, .halt_sel_i, .flash_sleep_i,
    .wake_ni, .rpin_ni, .osc_en_o, .pll_en_o, .core_clk_en_o,
    .resume_o, .state_o);

  // {hsel, flash, src(1=reset pin), exp_lock, len[3:0]}
  localparam logic [7:0] VEC [6] = '{
    8'b0_0_0_0_0010,  // mode not halt: ignored
    8'b1_0_0_0_0001,  // wake 1 cycle: too short
    8'b1_0_0_1_0010,  // wake 2 cycles: RAM resume
    8'b1_1_0_1_0101,  // wake 5: flash resume
    8'b1_0_1_0_0111,  // reset pin 7: too short
    8'b1_1_1_1_1000   // reset pin 8: flash resume
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_in(input logic [2:0] s, output int n);
    n = 0;
    while (state_o == s && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(state_o == 3'd0 && osc_en_o && pll_en_o && core_clk_en_o && resume_o,
        "R1 in reset", state_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(state_o == 3'd0 && resume_o, "R1 after reset", state_o, 0);
  endtask

  task automatic enter_halt(input bit flash);
    halt_sel_i = 1'b1; flash_sleep_i = flash; idle_req_i = 1'b1;
    @(negedge clk);
    idle_req_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int v = 0; v < 6; v++) begin
      logic hsel, fl, src, xl;
      int len;
      {hsel, fl, src, xl} = VEC[v][7:4];
      len = int'(VEC[v][3:0]);
      do_reset();
      halt_sel_i = hsel; flash_sleep_i = fl; idle_req_i = 1'b1;
      @(negedge clk);
      idle_req_i = 1'b0;
      if (!hsel) begin
        repeat (3) @(negedge clk);
        chk(state_o == 3'd0 && resume_o, "R2 idle ignored", state_o, 0);
        continue;
      end
      chk(state_o == 3'd1 && core_clk_en_o && !resume_o, "R2 flush entered", state_o, 1);
      flash_sleep_i = ~fl;  // must not matter (R8)
      count_in(3'd1, n);
      chk(n == 32, "R3 flush length", n, 32);
      chk(state_o == 3'd2, "R3 halted after flush", state_o, 2);
      chk(!osc_en_o && !pll_en_o && !core_clk_en_o, "R4 halted enables",
          {osc_en_o, pll_en_o, core_clk_en_o}, 0);
      if (src) rpin_ni = 1'b0; else wake_ni = 1'b0;
      @(negedge clk);
      chk(state_o == 3'd3 && osc_en_o && !pll_en_o && !core_clk_en_o,
          src ? "R9 osc up" : "R5 osc up", state_o, 3);
      repeat (len - 1) @(negedge clk);
      chk(state_o == 3'd3, "R5 osc held while low", state_o, 3);
      rpin_ni = 1'b1; wake_ni = 1'b1;
      @(negedge clk);
      chk(state_o == (xl ? 3'd4 : 3'd2), src ? "R9 pulse qual" : "R6 pulse qual",
          state_o, xl ? 4 : 2);
      if (!xl) continue;
      chk(pll_en_o && !core_clk_en_o, "R7 lock enables", {pll_en_o, core_clk_en_o}, 2);
      count_in(3'd4, n);
      chk(n == LOCK, "R7 lock length", n, LOCK);
      chk(state_o == 3'd5 && core_clk_en_o && !resume_o, "R8 resuming", state_o, 5);
      count_in(3'd5, n);
      chk(n == (fl ? 1125 : 35), "R8 resume delay latched", n, fl ? 1125 : 35);
      chk(state_o == 3'd0 && resume_o, "R8 back to run", state_o, 0);
    end

    // R11: pin low before halt is not a wake
    do_reset();
    wake_ni = 1'b0;
    enter_halt(1'b0);
    count_in(3'd1, n);
    repeat (5) @(negedge clk);
    chk(state_o == 3'd2, "R11 held low no wake", state_o, 2);
    wake_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(state_o == 3'd2, "R11 release alone no wake", state_o, 2);
    wake_ni = 1'b0;
    @(negedge clk);
    chk(state_o == 3'd3, "R11 new edge wakes", state_o, 3);
    wake_ni = 1'b1;
    @(negedge clk);
    chk(state_o == 3'd2, "R6 single cycle rejected", state_o, 2);
    chk(state_o <= 3'd5, "R10 legal encoding", state_o, 2);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule